// File: doc/BRIEF.md
# DMA Bus Request Sequencer with Interrupt Hold-off

This block sequences the bus ownership of a DMA engine. After a start pulse it waits for the peripheral to be ready, raises a bus request, waits for the bus acknowledge and then steps through a read phase and a write phase for every byte. The actual address and data paths are outside the block. They see a single transfer-step strobe, one per byte. A byte counter, loaded on start, decides when the programmed length has been reached.

A hold-off signal lets interrupt service routines run while a long transfer is in progress. The hold-off is formed from the interrupt status vector, the DMA interrupt enable mask and the vectored-interrupt mode flag. In continuous mode, an active hold-off makes the sequencer give the bus back at the next byte boundary and park in wait-ready. When the hold-off clears, the sequencer requests the bus again and goes straight to waiting for acknowledge. In burst mode the bus is instead released whenever ready is low at a byte boundary.

Top module: `dma_bus_sequencer`

## Requirements
- R1: After reset, seq_state is 0 (idle), bus_req is 0, xfer_step is 0 and holdoff is 0. The state codes are: 0 idle, 1 wait-ready, 2 request, 3 wait-acknowledge, 4 read phase, 5 write phase.
- R2: A stop pulse puts the sequencer in idle on the next edge from any state. bus_req drops on that edge if bus_ack is low; otherwise it stays high for one more cycle.
- R3: In idle, bus_req is driven low on the next edge, including when bus_ack is high.
- R4: holdoff is high one edge after im2_mode is high and (irq_status AND irq_dma_en) is nonzero, and low one edge after either condition goes away.
- R5: In wait-ready, with ready high and holdoff low, the sequencer passes through the request state (2) into wait-acknowledge (3) with bus_req high. While holdoff is high it stays in wait-ready with bus_req low.
- R6: A falling edge of holdoff seen in wait-ready raises bus_req and moves straight to wait-acknowledge on the next edge, whatever the level of ready.
- R7: The sequencer stays in wait-acknowledge until bus_ack is high, then runs the read phase and then the write phase. xfer_step is high exactly in the write phase.
- R8: Start loads byte_count with 0 when cont_mode is 1 and with 1 when cont_mode is 0. Each xfer_step adds one.
- R9: When the incremented count is at least xfer_len, the write phase releases bus_req and returns to idle. A transfer therefore always moves at least one byte.
- R10: In continuous mode, a high holdoff at the end of a write phase that is not the last one drops bus_req and returns to wait-ready. The transfer later resumes and completes the full length.
- R11: In burst mode, holdoff does not interrupt a running transfer. A low ready at the end of a write phase that is not the last one drops bus_req and returns to wait-ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse, taken in idle |
| stop | input | 1 | Disable pulse, forces idle |
| ready | input | 1 | Peripheral ready |
| cont_mode | input | 1 | 1 = continuous, 0 = burst |
| xfer_len | input | CW | Programmed transfer length |
| im2_mode | input | 1 | Vectored interrupt mode selected |
| irq_status | input | NIRQ | Pending interrupt status vector |
| irq_dma_en | input | NIRQ | Interrupts allowed to hold off DMA |
| bus_ack | input | 1 | Bus acknowledge |
| bus_req | output | 1 | Bus request |
| xfer_step | output | 1 | One-cycle strobe per byte moved |
| holdoff | output | 1 | Registered hold-off |
| seq_state | output | 3 | Sequencer state code |
| byte_count | output | CW | Byte counter |

## Verification
A wrong internal state shows up at the ports within one or two edges. An idle sequencer that still requests the bus leaves bus_req high one edge after acknowledge. A sequencer stuck in wait-ready after the hold-off clears never raises bus_req. A missed byte-boundary check shows as xfer_step pulses that continue while an interrupt is pending, or as a final byte_count that differs from the programmed length. The bench therefore counts strobes end to end and watches bus_req against the hold-off with cycle-exact sampling.

// File: rtl/dma_seq_pkg.sv
// Shared state encoding for the DMA bus sequencer.
// Assumes: 3-bit state code visible at the top-level port; idle must be zero.
package dma_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_WAIT_RDY = 3'd1,
        ST_REQUEST  = 3'd2,
        ST_WAIT_ACK = 3'd3,
        ST_READ     = 3'd4,
        ST_WRITE    = 3'd5
    } seq_state_t;
endpackage

// File: rtl/dma_holdoff_gen.sv
// Forms the registered DMA hold-off from masked pending interrupts and
// reports its falling edge.
// Assumes: interrupt inputs are synchronous to clk.
module dma_holdoff_gen #(
    parameter int NIRQ = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            im2_mode,
    input  logic [NIRQ-1:0] irq_status,
    input  logic [NIRQ-1:0] irq_dma_en,
    output logic            holdoff,
    output logic            holdoff_fall
);
    logic hold_q;
    logic hold_prev;
    logic masked_any;

    // Any enabled interrupt pending.
    assign masked_any = |(irq_status & irq_dma_en);

    // Register the hold-off and its previous value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q    <= 1'b0;
            hold_prev <= 1'b0;
        end else begin
            hold_q    <= im2_mode & masked_any;
            hold_prev <= hold_q;
        end
    end

    assign holdoff      = hold_q;
    assign holdoff_fall = hold_prev & ~hold_q;

    // R4
    holdoff_needs_im2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !im2_mode |=> !holdoff);

    // R4
    holdoff_follows_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (im2_mode && (irq_status & irq_dma_en) != '0) |=> holdoff);
endmodule

// File: rtl/dma_byte_counter.sv
// Byte counter for the transfer: loads 0 or 1 on start, counts strobes and
// flags the last byte when the incremented count reaches the length.
// Assumes: load and inc are never high in the same cycle.
module dma_byte_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          start_at_one,
    input  logic          inc,
    input  logic [CW-1:0] len,
    output logic [CW-1:0] count,
    output logic          last
);
    logic [CW-1:0] count_next;

    // Incremented value used for the length compare.
    assign count_next = count + 1'b1;
    assign last       = inc && (count_next >= len);

    // Load on start, advance on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= {{(CW-1){1'b0}}, start_at_one};
        end else if (inc) begin
            count <= count_next;
        end
    end

    // R8
    count_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> count == {{(CW-1){1'b0}}, $past(start_at_one)});

    // R8
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load) |=> count == $past(count) + 1'b1);
endmodule

// File: rtl/dma_seq_fsm.sv
// Bus ownership state machine: wait for ready, request, wait for acknowledge,
// read and write phases, with hold-off release and direct resume.
// Assumes: bus_ack is held while bus_req is held once granted.
module dma_seq_fsm
    import dma_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       stop,
    input  logic       ready,
    input  logic       bus_ack,
    input  logic       cont_mode,
    input  logic       holdoff,
    input  logic       holdoff_fall,
    input  logic       last,
    output seq_state_t state,
    output logic       bus_req,
    output logic       step,
    output logic       load
);
    logic release_now;

    // Byte-boundary release condition depends on mode.
    assign release_now = cont_mode ? holdoff : ~ready;
    assign step        = (state == ST_WRITE);
    assign load        = (state == ST_IDLE) && start && !stop;

    // State and bus request register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bus_req <= 1'b0;
        end else if (stop) begin
            state <= ST_IDLE;
            if (!bus_ack) bus_req <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    bus_req <= 1'b0;
                    if (start) state <= ST_WAIT_RDY;
                end
                ST_WAIT_RDY: begin
                    if (holdoff_fall) begin
                        bus_req <= 1'b1;
                        state   <= ST_WAIT_ACK;
                    end else if (ready && !holdoff) begin
                        state <= ST_REQUEST;
                    end
                end
                ST_REQUEST: begin
                    bus_req <= 1'b1;
                    state   <= ST_WAIT_ACK;
                end
                ST_WAIT_ACK: begin
                    if (bus_ack) state <= ST_READ;
                end
                ST_READ: begin
                    state <= ST_WRITE;
                end
                ST_WRITE: begin
                    if (last) begin
                        bus_req <= 1'b0;
                        state   <= ST_IDLE;
                    end else if (release_now) begin
                        bus_req <= 1'b0;
                        state   <= ST_WAIT_RDY;
                    end else begin
                        state <= ST_READ;
                    end
                end
                default: begin
                    bus_req <= 1'b0;
                    state   <= ST_IDLE;
                end
            endcase
        end
    end

    // R2
    stop_goes_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> state == ST_IDLE);

    // R3
    idle_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && bus_ack) |=> !bus_req);

    // R5
    req_rise_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> ($past(state) == ST_WAIT_RDY || $past(state) == ST_REQUEST));

    // R7
    wait_ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_ACK && !bus_ack && !stop) |=> state == ST_WAIT_ACK);

    // R7
    step_owns_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> bus_req);

    // R10
    cont_holdoff_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITE && cont_mode && holdoff && !last && !stop)
        |=> (state == ST_WAIT_RDY && !bus_req));
endmodule

// File: rtl/dma_bus_sequencer.sv
// Top level: DMA bus request sequencer with interrupt hold-off.
// Assumes: all inputs synchronous to clk; xfer_len and cont_mode stable
// during a transfer.
module dma_bus_sequencer
    import dma_seq_pkg::*;
#(
    parameter int CW   = 16,
    parameter int NIRQ = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            stop,
    input  logic            ready,
    input  logic            cont_mode,
    input  logic [CW-1:0]   xfer_len,
    input  logic            im2_mode,
    input  logic [NIRQ-1:0] irq_status,
    input  logic [NIRQ-1:0] irq_dma_en,
    input  logic            bus_ack,
    output logic            bus_req,
    output logic            xfer_step,
    output logic            holdoff,
    output logic [2:0]      seq_state,
    output logic [CW-1:0]   byte_count
);
    logic       hold_fall;
    logic       last_byte;
    logic       load_cnt;
    seq_state_t state;

    dma_holdoff_gen #(.NIRQ(NIRQ)) u_holdoff (
        .clk          (clk),
        .rst_n        (rst_n),
        .im2_mode     (im2_mode),
        .irq_status   (irq_status),
        .irq_dma_en   (irq_dma_en),
        .holdoff      (holdoff),
        .holdoff_fall (hold_fall)
    );

    dma_byte_counter #(.CW(CW)) u_counter (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (load_cnt),
        .start_at_one (~cont_mode),
        .inc          (xfer_step),
        .len          (xfer_len),
        .count        (byte_count),
        .last         (last_byte)
    );

    dma_seq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .stop         (stop),
        .ready        (ready),
        .bus_ack      (bus_ack),
        .cont_mode    (cont_mode),
        .holdoff      (holdoff),
        .holdoff_fall (hold_fall),
        .last         (last_byte),
        .state        (state),
        .bus_req      (bus_req),
        .step         (xfer_step),
        .load         (load_cnt)
    );

    assign seq_state = state;

    // R9
    finish_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_step && last_byte && !stop) |=> (!bus_req && seq_state == 3'd0));
endmodule

// File: tb/dma_bus_sequencer_test.sv
// Self-checking bench: table of transfers, then directed corner cases.
module dma_bus_sequencer_test;
    localparam int CW   = 16;
    localparam int NIRQ = 14;
    localparam int NVEC = 6;

    // Table: mode, length, expected strobes, expected final count.
    localparam bit VCONT [NVEC] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
    localparam int VLEN  [NVEC] = '{4, 1, 5, 1, 0, 2};
    localparam int VBYTE [NVEC] = '{4, 1, 4, 1, 1, 1};
    localparam int VCNT  [NVEC] = '{4, 1, 5, 2, 1, 2};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, stop = 1'b0, ready = 1'b0, cont_mode = 1'b1;
    logic [CW-1:0] xfer_len = '0;
    logic im2_mode = 1'b0;
    logic [NIRQ-1:0] irq_status = '0, irq_dma_en = '0;
    logic bus_ack = 1'b0;
    logic bus_req, xfer_step, holdoff;
    logic [2:0] seq_state;
    logic [CW-1:0] byte_count;
    logic auto_ack = 1'b1;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    // Bus arbiter model: grant one edge after request.
    always @(posedge clk) bus_ack <= auto_ack & bus_req;

    dma_bus_sequencer #(.CW(CW), .NIRQ(NIRQ)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .ready(ready),
        .cont_mode(cont_mode), .xfer_len(xfer_len), .im2_mode(im2_mode),
        .irq_status(irq_status), .irq_dma_en(irq_dma_en), .bus_ack(bus_ack),
        .bus_req(bus_req), .xfer_step(xfer_step), .holdoff(holdoff),
        .seq_state(seq_state), .byte_count(byte_count)
    );

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_start();
        start = 1'b1; tick(1); start = 1'b0;
    endtask

    // Run until idle, counting strobes.
    task automatic wait_idle(input int limit, output int steps);
        steps = 0;
        for (int i = 0; i < limit; i++) begin
            if (xfer_step) steps++;
            if (seq_state == 3'd0) break;
            tick(1);
        end
    endtask

    task automatic wait_count(input int n);
        for (int i = 0; i < 200; i++) begin
            if (byte_count >= CW'(n)) break;
            tick(1);
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: got 0 expected 1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int steps;
        bit dropped;
        tick(3);
        // R1 reset state
        check("R1 state", seq_state, 0);
        check("R1 bus_req", bus_req, 0);
        check("R1 xfer_step", xfer_step, 0);
        check("R1 holdoff", holdoff, 0);
        rst_n = 1'b1;
        tick(1);

        // R8 R9 table of transfers
        ready = 1'b1;
        for (int v = 0; v < NVEC; v++) begin
            cont_mode = VCONT[v];
            xfer_len  = CW'(VLEN[v]);
            pulse_start();
            wait_idle(300, steps);
            check("R9 strobes", steps, VBYTE[v]);
            check("R8 final count", int'(byte_count), VCNT[v]);
            check("R9 released", bus_req, 0);
            tick(2);
        end

        // R4 hold-off formation
        irq_dma_en = 14'h0005; irq_status = 14'h0004; im2_mode = 1'b0;
        tick(2);
        check("R4 no im2", holdoff, 0);
        im2_mode = 1'b1; irq_status = 14'h0002;
        tick(2);
        check("R4 disjoint", holdoff, 0);
        irq_status = 14'h0004;
        tick(1);
        check("R4 overlap", holdoff, 1);

        // R5 R6 hold-off blocks request, falling edge resumes at wait-ack
        cont_mode = 1'b1; xfer_len = CW'(3); ready = 1'b1;
        pulse_start();
        tick(3);
        check("R5 held state", seq_state, 1);
        check("R5 held req", bus_req, 0);
        ready = 1'b0; irq_status = '0;
        tick(1);
        check("R6 before fall", seq_state, 1);
        tick(1);
        check("R6 direct wait-ack", seq_state, 3);
        check("R6 req", bus_req, 1);
        ready = 1'b1;
        wait_idle(300, steps);
        check("R6 completes", int'(byte_count), 3);

        // R10 continuous release on hold-off and resume
        xfer_len = CW'(20);
        pulse_start();
        wait_count(3);
        irq_status = 14'h0001;
        for (int i = 0; i < 12; i++) begin
            if (!bus_req) break;
            tick(1);
        end
        check("R10 released", bus_req, 0);
        check("R10 wait-ready", seq_state, 1);
        check("R10 partial", int'(byte_count < CW'(20)), 1);
        tick(5);
        check("R10 parked", seq_state, 1);
        irq_status = '0;
        wait_idle(400, steps);
        check("R10 full length", int'(byte_count), 20);

        // R11 burst ignores hold-off mid-transfer
        cont_mode = 1'b0; xfer_len = CW'(6);
        pulse_start();
        wait_count(2);
        irq_status = 14'h0001;
        dropped = 1'b0;
        for (int i = 0; i < 100; i++) begin
            if (seq_state == 3'd0) break;
            if (seq_state >= 3'd3 && !bus_req) dropped = 1'b1;
            tick(1);
        end
        check("R11 no drop", dropped, 0);
        check("R11 count", int'(byte_count), 6);
        irq_status = '0;
        tick(3);

        // R11 burst releases when ready low
        xfer_len = CW'(10);
        pulse_start();
        wait_count(3);
        ready = 1'b0;
        for (int i = 0; i < 10; i++) begin
            if (!bus_req) break;
            tick(1);
        end
        check("R11 ready release", bus_req, 0);
        check("R11 ready state", seq_state, 1);
        ready = 1'b1;
        wait_idle(300, steps);
        check("R11 resumes", int'(byte_count), 10);

        // R7 waits for acknowledge
        cont_mode = 1'b1; xfer_len = CW'(2); auto_ack = 1'b0;
        pulse_start();
        tick(6);
        check("R7 wait-ack", seq_state, 3);
        check("R7 no strobe", int'(byte_count), 0);
        // R2 stop without acknowledge drops request at once
        stop = 1'b1; tick(1); stop = 1'b0;
        check("R2 idle no ack", seq_state, 0);
        check("R2 req no ack", bus_req, 0);
        auto_ack = 1'b1;
        tick(2);

        // R2 R3 stop while owning the bus
        xfer_len = CW'(50);
        pulse_start();
        wait_count(2);
        stop = 1'b1; tick(1); stop = 1'b0;
        check("R2 idle", seq_state, 0);
        check("R2 req held", bus_req, 1);
        tick(1);
        check("R3 idle drop", bus_req, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule